// File: doc/BRIEF.md
# Lockable Flash Control Register

This block is the command register of an embedded flash controller. Software reaches it over a simple register bus with a byte-enable per lane. Through it, software picks the operation (program, sector erase, whole-array erase, or erase of the upper bank), the target sector and the program width. It then fires a start trigger and sets two interrupt enables. The register drives these fields straight to the erase/program sequencer. That sequencer, the flash array and the status register are outside the block. They show up here only as a busy input and two flag inputs.

The register leaves reset locked. While locked it accepts only a write that sets the lock bit again. To clear the lock, software writes two fixed full-word keys, in order, to a separate key address. Any other write to the key address while locked counts as a failed attempt. After a failed attempt the lock stays set until the next reset. The start bit is set by software and clears itself when the busy input falls. The interrupt request is formed from the enables and the flag inputs.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset, the word read at the control address (0x10) is 0x8000_0000: the lock bit (bit 31) is set and every other bit is 0. The interrupt output and the start output are 0.
- R2: While the lock bit is set, a write to the control address changes no bit other than the lock. A write of 1 to bit 31, with byte lane 3 enabled, sets the lock in every state. Writing 0 to bit 31 never clears it.
- R3: While locked and not failed, a full-word write of 0x45670123 to the key address (0x04), followed by a full-word write of 0xCDEF89AB there, clears the lock on the edge of the second write. No other event clears the lock.
- R4: While locked, a write to the key address that breaks the sequence is a failed attempt. This covers a wrong value, the second key first, or byte enables other than 4'hF. After a failed attempt the lock stays set, even through a later correct sequence, until reset.
- R5: While unlocked and not busy, a write updates only the enabled byte lanes. The writable fields are: error-interrupt enable at bit 25, end-of-operation-interrupt enable at bit 24, upper-bank erase at bit 15, program width at bits 9:8 (00 x8, 01 x16, 10 x32, 11 x64), sector number at bits 7:3, whole erase at bit 2, sector erase at bit 1 and program at bit 0.
- R6: The start bit (bit 16) is set by writing 1 to it. Writing 0 to it has no effect. It clears on the clock edge at which busy is sampled 0 after being 1, and it is driven on the start output.
- R7: While busy is 1, writes to the control address leave every bit unchanged, except that a write setting the lock bit is still accepted.
- R8: Bits 30:26, 23:17 and 14:10 always read 0.
- R9: The interrupt output is combinational: (bit 25 AND the operation-error input) OR (bit 24 AND the end-of-operation input).
- R10: The key address reads 0. Writes to it while unlocked have no effect, so after software re-locks, a fresh correct sequence unlocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| busy_i | input | 1 | Sequencer busy |
| op_err_i | input | 1 | Operation-error flag |
| eop_i | input | 1 | End-of-operation flag |
| irq_o | output | 1 | Interrupt request |
| start_o | output | 1 | Start trigger to the sequencer |
| prog_o | output | 1 | Program operation selected |
| sect_erase_o | output | 1 | Sector erase selected |
| mass_erase_o | output | 1 | Whole-array erase selected |
| bank2_erase_o | output | 1 | Upper-bank erase selected |
| sector_o | output | 5 | Sector number |
| psize_o | output | 2 | Program width code |

## Verification
The bench checks that a wrong key, a partial-lane key write or reversed keys all leave the register locked for good. A design that only restarts the sequence would unlock on the next correct pair. It checks that key writes made while unlocked are harmless, since a design that counts them as failures would refuse a later legitimate unlock. It also checks that writes during busy are dropped except for re-locking, and that the start bit survives a written 0 and clears only on the busy fall. A design that confused lanes or let the byte-3 write change the enables while busy would show the wrong word.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int SECT_W = 5;

    localparam int LOCK_BIT  = 31;
    localparam int ERREN_BIT = 25;
    localparam int EOPEN_BIT = 24;
    localparam int START_BIT = 16;
    localparam int BANK2_BIT = 15;
    localparam int PSZ_LO    = 8;
    localparam int SECT_LO   = 3;
    localparam int MASS_BIT  = 2;
    localparam int SERA_BIT  = 1;
    localparam int PROG_BIT  = 0;

    localparam logic [DATA_W-1:0] RESET_WORD = 32'h8000_0000;
    localparam logic [DATA_W-1:0] LIVE_MASK  = 32'h8301_83FF;
    localparam logic [DATA_W-1:0] HOLD_MASK  = 32'h0300_83FF;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB;

    typedef enum logic [1:0] {
        PSZ_X8  = 2'b00,
        PSZ_X16 = 2'b01,
        PSZ_X32 = 2'b10,
        PSZ_X64 = 2'b11
    } psize_e;

    typedef enum logic [1:0] {
        KS_WAIT_A = 2'b00,
        KS_WAIT_B = 2'b01,
        KS_DEAD   = 2'b10
    } key_state_e;

    typedef struct packed {
        logic              lock;
        logic              err_en;
        logic              eop_en;
        logic              start;
        logic              bank2;
        psize_e            psize;
        logic [SECT_W-1:0] sector;
        logic              mass;
        logic              sect_er;
        logic              prog;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        lock: 1'b1, err_en: 1'b0, eop_en: 1'b0, start: 1'b0, bank2: 1'b0,
        psize: PSZ_X8, sector: '0, mass: 1'b0, sect_er: 1'b0, prog: 1'b0
    };

    function automatic logic [DATA_W-1:0] ctl_pack(input ctl_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[LOCK_BIT]                   = f.lock;
        w[ERREN_BIT]                  = f.err_en;
        w[EOPEN_BIT]                  = f.eop_en;
        w[START_BIT]                  = f.start;
        w[BANK2_BIT]                  = f.bank2;
        w[PSZ_LO +: 2]                = f.psize;
        w[SECT_LO +: SECT_W]          = f.sector;
        w[MASS_BIT]                   = f.mass;
        w[SERA_BIT]                   = f.sect_er;
        w[PROG_BIT]                   = f.prog;
        return w;
    endfunction

    function automatic ctl_t ctl_unpack(input logic [DATA_W-1:0] w);
        ctl_t f;
        f.lock    = w[LOCK_BIT];
        f.err_en  = w[ERREN_BIT];
        f.eop_en  = w[EOPEN_BIT];
        f.start   = w[START_BIT];
        f.bank2   = w[BANK2_BIT];
        f.psize   = psize_e'(w[PSZ_LO +: 2]);
        f.sector  = w[SECT_LO +: SECT_W];
        f.mass    = w[MASS_BIT];
        f.sect_er = w[SERA_BIT];
        f.prog    = w[PROG_BIT];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] m;
        m = old_w;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) m[i*8 +: 8] = new_w[i*8 +: 8];
        end
        return m;
    endfunction

endpackage

// File: rtl/flash_key_unlock.sv
module flash_key_unlock
    import flash_ctl_pkg::*;
#(
    parameter int                DW    = DATA_W,
    parameter logic [DW-1:0]     KEY_A = KEY_FIRST,
    parameter logic [DW-1:0]     KEY_B = KEY_SECOND
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    input  logic          key_full,
    input  logic          locked,
    output logic          unlock
);
    key_state_e state_q, state_d;
    logic       hit_a, hit_b, live;

    assign hit_a = key_full && (key_data == KEY_A);
    assign hit_b = key_full && (key_data == KEY_B);
    assign live  = key_wr && locked;

    always_comb begin
        state_d = state_q;
        unlock  = 1'b0;
        if (live) begin
            unique case (state_q)
                KS_WAIT_A: state_d = hit_a ? KS_WAIT_B : KS_DEAD;
                KS_WAIT_B: begin
                    if (hit_b) begin
                        state_d = KS_WAIT_A;
                        unlock  = 1'b1;
                    end else begin
                        state_d = KS_DEAD;
                    end
                end
                default:   state_d = KS_DEAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_WAIT_A;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/flash_ctl_fields.sv
module flash_ctl_fields
    import flash_ctl_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    input  logic [BW-1:0] be,
    input  logic          busy,
    input  logic          unlock,
    output ctl_t          q
);
    localparam int LOCK_LANE  = LOCK_BIT / 8;
    localparam int START_LANE = START_BIT / 8;

    ctl_t          d, merged;
    logic          busy_q;
    logic          busy_fall;
    logic          editable;
    logic          set_lock;
    logic          set_start;

    assign busy_fall = busy_q && !busy;
    assign editable  = wr_ctl && !q.lock && !busy;
    assign set_lock  = wr_ctl && be[LOCK_LANE] && wdata[LOCK_BIT];
    assign set_start = editable && be[START_LANE] && wdata[START_BIT];
    assign merged    = ctl_unpack(lane_merge(ctl_pack(q), wdata, be));

    always_comb begin
        d = q;
        if (editable) begin
            d.err_en  = merged.err_en;
            d.eop_en  = merged.eop_en;
            d.bank2   = merged.bank2;
            d.psize   = merged.psize;
            d.sector  = merged.sector;
            d.mass    = merged.mass;
            d.sect_er = merged.sect_er;
            d.prog    = merged.prog;
        end
        if (set_lock)    d.lock = 1'b1;
        else if (unlock) d.lock = 1'b0;
        if (set_start)      d.start = 1'b1;
        else if (busy_fall) d.start = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= CTL_RESET;
            busy_q <= 1'b0;
        end else begin
            q      <= d;
            busy_q <= busy;
        end
    end

endmodule

// File: rtl/flash_irq_gen.sv
module flash_irq_gen #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] enable,
    input  logic [NSRC-1:0] flag,
    output logic            irq
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = enable[g] && flag[g];
    end

    assign irq = |hit;

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
    import flash_ctl_pkg::*;
#(
    parameter int                 ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]  CTL_OFS = 8'h10,
    parameter logic [ADDR_W-1:0]  KEY_OFS = 8'h04,
    parameter logic [DATA_W-1:0]  KEY_A   = KEY_FIRST,
    parameter logic [DATA_W-1:0]  KEY_B   = KEY_SECOND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy_i,
    input  logic              op_err_i,
    input  logic              eop_i,
    output logic              irq_o,
    output logic              start_o,
    output logic              prog_o,
    output logic              sect_erase_o,
    output logic              mass_erase_o,
    output logic              bank2_erase_o,
    output logic [SECT_W-1:0] sector_o,
    output logic [1:0]        psize_o
);
    ctl_t              ctl;
    logic [DATA_W-1:0] ctl_word;
    logic              wr_ctl, wr_key, unlock;

    assign wr_ctl = bus_wr && (bus_addr == CTL_OFS);
    assign wr_key = bus_wr && (bus_addr == KEY_OFS);

    flash_key_unlock #(
        .DW(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
    ) u_keys (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr_key),
        .key_data (bus_wdata),
        .key_full (&bus_be),
        .locked   (ctl.lock),
        .unlock   (unlock)
    );

    flash_ctl_fields #(.DW(DATA_W)) u_fields (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (wr_ctl),
        .wdata  (bus_wdata),
        .be     (bus_be),
        .busy   (busy_i),
        .unlock (unlock),
        .q      (ctl)
    );

    flash_irq_gen #(.NSRC(2)) u_irq (
        .enable ({ctl.err_en, ctl.eop_en}),
        .flag   ({op_err_i,   eop_i}),
        .irq    (irq_o)
    );

    assign ctl_word      = ctl_pack(ctl);
    assign bus_rdata     = (bus_addr == CTL_OFS) ? ctl_word : '0;
    assign start_o       = ctl.start;
    assign prog_o        = ctl.prog;
    assign sect_erase_o  = ctl.sect_er;
    assign mass_erase_o  = ctl.mass;
    assign bank2_erase_o = ctl.bank2;
    assign sector_o      = ctl.sector;
    assign psize_o       = ctl.psize;

endmodule

// File: rtl/flash_ctl_reg_chk.sv
module flash_ctl_reg_chk
    import flash_ctl_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CTL_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] KEY_OFS = 8'h04,
    parameter logic [DATA_W-1:0] KEY_B   = KEY_SECOND
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [BE_W-1:0]   bus_be,
    input logic              busy_i,
    input logic              op_err_i,
    input logic              eop_i,
    input logic              irq_o,
    input logic [DATA_W-1:0] ctl_word
);
    logic prev_busy;
    logic start_write;
    logic lock_write;

    always_ff @(posedge clk) begin
        if (rst) prev_busy <= 1'b0;
        else     prev_busy <= busy_i;
    end

    assign start_write = bus_wr && (bus_addr == CTL_OFS) && bus_be[START_BIT/8]
                         && bus_wdata[START_BIT] && !ctl_word[LOCK_BIT] && !busy_i;
    assign lock_write  = bus_wr && (bus_addr == CTL_OFS) && bus_be[LOCK_BIT/8]
                         && bus_wdata[LOCK_BIT];

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ctl_word & ~LIVE_MASK) == '0); // R8
    AST_LOCK_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_word[LOCK_BIT]) |-> $past(bus_wr && bus_addr == KEY_OFS
                                            && bus_wdata == KEY_B && (&bus_be))); // R3
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (rst)
        lock_write |=> ctl_word[LOCK_BIT]); // R2
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctl_word[LOCK_BIT] |=> $stable(ctl_word & HOLD_MASK)); // R2
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(ctl_word & HOLD_MASK)); // R7
    AST_START_FALL: assert property (@(posedge clk) disable iff (rst)
        (prev_busy && !busy_i && !start_write) |=> !ctl_word[START_BIT]); // R6
    AST_IRQ_ERR: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[ERREN_BIT] && op_err_i) |-> irq_o); // R9
    AST_IRQ_EOP: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[EOPEN_BIT] && eop_i) |-> irq_o); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!(ctl_word[ERREN_BIT] && op_err_i) && !(ctl_word[EOPEN_BIT] && eop_i))
        |-> !irq_o); // R9

endmodule

bind flash_ctl_reg flash_ctl_reg_chk #(
    .ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS), .KEY_OFS(KEY_OFS), .KEY_B(KEY_B)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .busy_i    (busy_i),
    .op_err_i  (op_err_i),
    .eop_i     (eop_i),
    .irq_o     (irq_o),
    .ctl_word  (ctl_word)
);

// File: tb/tb_flash_ctl_reg.sv
module tb_flash_ctl_reg;
    localparam logic [7:0]  CTL  = 8'h10;
    localparam logic [7:0]  KEY  = 8'h04;
    localparam logic [31:0] KA   = 32'h4567_0123;
    localparam logic [31:0] KB   = 32'hCDEF_89AB;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        busy;
        logic [7:0]  req;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{CTL, 32'h0000_03FF, 4'hF, 1'b0, 8'd2,  32'h8000_0000}, // R2 locked write dropped
        '{CTL, 32'h0000_0000, 4'hF, 1'b0, 8'd2,  32'h8000_0000}, // R2 lock not cleared by 0
        '{KEY, KA,            4'hF, 1'b0, 8'd3,  32'h8000_0000}, // R3 first key
        '{KEY, KB,            4'hF, 1'b0, 8'd3,  32'h0000_0000}, // R3 second key unlocks
        '{CTL, 32'h7FFF_FFFF, 4'hF, 1'b0, 8'd8,  32'h0301_83FF}, // R8 R5 reserved stay 0
        '{CTL, 32'h0000_0000, 4'hF, 1'b0, 8'd6,  32'h0001_0000}, // R6 start survives 0
        '{CTL, 32'hFFFF_FFFF, 4'h1, 1'b0, 8'd5,  32'h0001_00FF}, // R5 lane 0 only
        '{CTL, 32'h0000_0100, 4'h2, 1'b0, 8'd5,  32'h0001_01FF}, // R5 lane 1, width x16
        '{CTL, 32'h0300_0000, 4'hF, 1'b1, 8'd7,  32'h0001_01FF}, // R7 busy drops write
        '{CTL, 32'h0000_0000, 4'h4, 1'b0, 8'd6,  32'h0000_01FF}, // R6 busy fall clears start
        '{CTL, 32'h8300_0000, 4'h8, 1'b1, 8'd7,  32'h8000_01FF}, // R7 lock accepted in busy
        '{KEY, KA,            4'hF, 1'b0, 8'd3,  32'h8000_01FF}, // R3
        '{KEY, KB,            4'hF, 1'b0, 8'd3,  32'h0000_01FF}  // R3
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata;
    logic        busy_i, op_err_i, eop_i;
    logic        irq_o, start_o, prog_o, sect_erase_o, mass_erase_o, bank2_erase_o;
    logic [4:0]  sector_o;
    logic [1:0]  psize_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flash_ctl_reg dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .busy_i(busy_i), .op_err_i(op_err_i), .eop_i(eop_i), .irq_o(irq_o),
        .start_o(start_o), .prog_o(prog_o), .sect_erase_o(sect_erase_o),
        .mass_erase_o(mass_erase_o), .bank2_erase_o(bank2_erase_o),
        .sector_o(sector_o), .psize_o(psize_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = CTL; bus_wdata = '0; bus_be = '0;
        #1;
    endtask

    task automatic read_ctl(input string req, input logic [31:0] exp);
        bus_addr = CTL;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        busy_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        bus_wr = 1'b0; bus_addr = CTL; bus_wdata = '0; bus_be = '0;
        op_err_i = 1'b0; eop_i = 1'b0;
        do_reset();

        read_ctl("R1 reset word", 32'h8000_0000);
        check("R1 irq at reset", {31'd0, irq_o}, 32'd0);
        check("R1 start at reset", {31'd0, start_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            busy_i = VEC[i].busy;
            @(negedge clk);
            bus_write(VEC[i].addr, VEC[i].data, VEC[i].be);
            read_ctl($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
        end

        // R5 decoded outputs after vectors: width x16, sector 31, all ops
        check("R5 psize out", {30'd0, psize_o}, 32'd1);
        check("R5 sector out", {27'd0, sector_o}, 32'd31);

        // R10 key address reads 0, unlocked key writes harmless
        bus_addr = KEY; #1;
        check("R10 key reads 0", bus_rdata, 32'd0);
        bus_write(KEY, 32'hDEAD_BEEF, 4'hF);
        read_ctl("R10 unlocked key write", 32'h0000_01FF);

        // R9 interrupt combinations
        bus_write(CTL, 32'h0200_0000, 4'h8);
        read_ctl("R5 err enable", 32'h0200_01FF);
        op_err_i = 1'b1; #1;
        check("R9 err irq", {31'd0, irq_o}, 32'd1);
        op_err_i = 1'b0; eop_i = 1'b1; #1;
        check("R9 eop masked", {31'd0, irq_o}, 32'd0);
        bus_write(CTL, 32'h0100_0000, 4'h8);
        check("R9 eop irq", {31'd0, irq_o}, 32'd1);
        eop_i = 1'b0; op_err_i = 1'b1; #1;
        check("R9 err masked", {31'd0, irq_o}, 32'd0);
        op_err_i = 1'b0;

        // R10 relock then fresh sequence still works
        bus_write(CTL, 32'h8000_0000, 4'h8);
        read_ctl("R2 relock", 32'h8000_01FF);
        bus_write(KEY, KA, 4'hF);
        bus_write(KEY, KB, 4'hF);
        read_ctl("R10 unlock after relock", 32'h0000_01FF);

        // R4 reversed keys
        bus_write(CTL, 32'h8000_0000, 4'h8);
        bus_write(KEY, KB, 4'hF);
        bus_write(KEY, KA, 4'hF);
        bus_write(KEY, KB, 4'hF);
        read_ctl("R4 reversed keys stuck", 32'h8000_01FF);
        bus_write(CTL, 32'h0000_0000, 4'hF);
        read_ctl("R4 stuck ignores write", 32'h8000_01FF);

        do_reset();
        read_ctl("R1 reset after stuck", 32'h8000_0000);

        // R4 wrong second key
        bus_write(KEY, KA, 4'hF);
        bus_write(KEY, 32'h1234_5678, 4'hF);
        bus_write(KEY, KA, 4'hF);
        bus_write(KEY, KB, 4'hF);
        read_ctl("R4 wrong second key", 32'h8000_0000);

        // R4 partial lanes on a key write
        do_reset();
        bus_write(KEY, KA, 4'h7);
        bus_write(KEY, KA, 4'hF);
        bus_write(KEY, KB, 4'hF);
        read_ctl("R4 partial key lanes", 32'h8000_0000);

        // R3 clean unlock after reset
        do_reset();
        bus_write(KEY, KA, 4'hF);
        bus_write(KEY, KB, 4'hF);
        read_ctl("R3 unlock", 32'h0000_0000);

        // R6 start output and busy fall
        bus_write(CTL, 32'h0001_0000, 4'h4);
        check("R6 start set", {31'd0, start_o}, 32'd1);
        busy_i = 1'b1;
        @(negedge clk); #1;
        check("R6 start held in busy", {31'd0, start_o}, 32'd1);
        busy_i = 1'b0;
        @(negedge clk); #1;
        check("R6 start cleared", {31'd0, start_o}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule